// File: doc/BRIEF.md
# Prefixed instruction fusion decoder

This block sits at the front of instruction decode for a stream of fixed 32-bit words. Some operations are encoded as two words: a prefix word, recognised by a primary opcode (bits 31:26) of 1, followed by an ordinary suffix word. For every fetched word the block also receives a class code from an earlier lookup. When a prefix arrives, the block keeps it and produces nothing in that cycle. The next valid word is taken as the suffix, and the block emits one fused operation built from the two words.

A fused output carries the prefixed class code, which is the suffix class with its least significant bit set. It also carries a flag that says whether the prefix form agrees with the suffix class, both raw words, and the address of the prefix. The prefix address is rebuilt from address bits 5:2 saved in the prefix cycle. This works because a prefix/suffix pair never straddles a 64-byte boundary. Unprefixed words pass through unchanged, except for the two doubleword suffix classes, which are only legal behind a prefix. A flush drops any held prefix, and a stall freezes the whole block.

Top module: `pfx_fuse_dec`

## Requirements
- R1: After reset the output valid is low and no prefix is held, so the first accepted word that is not a prefix comes out unfused.
- R2: An accepted word whose bits 31:26 equal 1, arriving while no prefix is held, is stored as the prefix, and output valid is low in the following cycle.
- R3: With a prefix held, the next accepted word is the suffix. One cycle later the output is valid with fused = 1, class = suffix class with bit 0 set, prefix = the held word and suffix = the new word. Cycles with input valid low in between do not use up the held prefix.
- R4: An accepted word that is not a prefix, arriving with no prefix held, comes out one cycle later with fused = 0, legality flag = 1, prefix field = 0, the word itself, its class and its own address.
- R5: Class codes 28 (doubleword load suffix) and 30 (doubleword store suffix) come out as class 0 (illegal) when they arrive unprefixed. Behind a prefix they become 29 and 31.
- R6: The legality flag of a fused output is 1 only when prefix bit 23 is 0 and one of these holds: bits 25:24 = 0 and the suffix class is 26, 28 or 30; bits 25:24 = 2 and the suffix class is even and from 2 to 24; bits 25:24 = 3 and the suffix class is 32 (the prefixed no-op). Bits 25:24 = 1 always give 0.
- R7: The legality result never changes the emitted class. An illegal pairing still emits the suffix class with bit 0 set.
- R8: The address of a fused output is the suffix fetch address with bits 5:2 replaced by bits 5:2 of the prefix fetch address.
- R9: Flush clears any held prefix and drives output valid low in the next cycle. A word presented during the flush cycle is discarded.
- R10: While stall is high (and flush low), every output and the held prefix keep their values, and presented words are not consumed.
- R11: A word with bits 31:26 = 1 that arrives while a prefix is held is taken as the suffix, not as a new prefix.
- R12: A cycle with stall low and input valid low makes output valid low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Drops the held prefix and the pending output |
| out_stall_i | input | 1 | Freezes the block; input is not consumed |
| in_valid_i | input | 1 | Qualifies the input word |
| in_word_i | input | 32 | Fetched instruction word |
| in_addr_i | input | ADDR_W | Fetch address of the word |
| in_class_i | input | 6 | Class code from the lookup for this word |
| out_valid_o | output | 1 | Decoded operation valid |
| out_class_o | output | 6 | Emitted class code |
| out_fused_o | output | 1 | Operation was built from a prefix and a suffix |
| out_pfx_ok_o | output | 1 | Prefix form agrees with the suffix class |
| out_prefix_o | output | 32 | Prefix word, zero when unfused |
| out_suffix_o | output | 32 | The word itself, or the suffix |
| out_addr_o | output | ADDR_W | Operation address (prefix address when fused) |

## Verification
The assertions assume that upstream keeps a word steady and presents it again after a stall, since the block gives no ready signal. They also assume that the lookup class for a prefix word is the odd code 1, and that a prefix and its suffix share one 64-byte window. The stimulus re-presents any word that was offered during a stall or a flush. Each prefix and its suffix are placed at consecutive word addresses inside one 64-byte block. The suffix address is deliberately given different bits 5:2, so that the rebuilt prefix address can be told apart from the raw suffix address.

// File: rtl/pfx_fuse_pkg.sv
package pfx_fuse_pkg;

    localparam int WORD_W = 32;
    localparam int CLS_W  = 6;
    localparam int OPC_W  = 6;
    localparam int OPC_LO = WORD_W - OPC_W;
    localparam logic [OPC_W-1:0] OPC_PREFIX = 6'd1;

    // prefix header bits 25:23 -> form (25:24) and subtype (23)
    localparam int HDR_HI = 25;
    localparam int HDR_LO = 23;
    localparam int HDR_W  = HDR_HI - HDR_LO + 1;

    typedef enum logic [1:0] {
        FORM_EIGHT_LS = 2'd0,
        FORM_RSVD     = 2'd1,
        FORM_MOD_LS   = 2'd2,
        FORM_NOP      = 2'd3
    } pfx_form_e;

    // class codes: suffixes even, prefixed variant = code | 1
    localparam logic [CLS_W-1:0] CLS_ILLEGAL   = 6'd0;
    localparam logic [CLS_W-1:0] CLS_PFX_WORD  = 6'd1;
    localparam logic [CLS_W-1:0] CLS_LD_B      = 6'd2;
    localparam logic [CLS_W-1:0] CLS_ADD_IMM   = 6'd24;
    localparam logic [CLS_W-1:0] CLS_LD_WA_SFX = 6'd26;
    localparam logic [CLS_W-1:0] CLS_LD_DW_SFX = 6'd28;
    localparam logic [CLS_W-1:0] CLS_ST_DW_SFX = 6'd30;
    localparam logic [CLS_W-1:0] CLS_NOP_SFX   = 6'd32;

    function automatic logic cls_is_dummy(input logic [CLS_W-1:0] c);
        return (c == CLS_LD_DW_SFX) || (c == CLS_ST_DW_SFX);
    endfunction

    function automatic logic cls_fits_mod(input logic [CLS_W-1:0] c);
        return !c[0] && (c >= CLS_LD_B) && (c <= CLS_ADD_IMM);
    endfunction

    function automatic logic cls_fits_eight(input logic [CLS_W-1:0] c);
        return (c == CLS_LD_WA_SFX) || cls_is_dummy(c);
    endfunction

    function automatic logic [CLS_W-1:0] cls_prefixed(input logic [CLS_W-1:0] c);
        return c | {{(CLS_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/pfx_word_sort.sv
module pfx_word_sort
    import pfx_fuse_pkg::*;
(
    input  logic             vld_i,
    input  logic             go_i,
    input  logic             held_i,
    input  logic [OPC_W-1:0] opc_i,
    output logic             as_pfx_o,
    output logic             as_sfx_o,
    output logic             as_plain_o
);
    logic take;
    logic opc_is_pfx;

    always_comb begin
        take       = vld_i && go_i;
        opc_is_pfx = (opc_i == OPC_PREFIX);
        as_sfx_o   = take && held_i;
        as_pfx_o   = take && !held_i && opc_is_pfx;
        as_plain_o = take && !held_i && !opc_is_pfx;
    end
endmodule

// File: rtl/pfx_legal_chk.sv
module pfx_legal_chk
    import pfx_fuse_pkg::*;
(
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [CLS_W-1:0] cls_i,
    output logic             ok_o
);
    pfx_form_e form;
    logic      sub;

    always_comb begin
        form = pfx_form_e'(hdr_i[HDR_W-1:HDR_W-2]);
        sub  = hdr_i[0];
        ok_o = 1'b0;
        if (!sub) begin
            unique case (form)
                FORM_EIGHT_LS: ok_o = cls_fits_eight(cls_i);
                FORM_MOD_LS:   ok_o = cls_fits_mod(cls_i);
                FORM_NOP:      ok_o = (cls_i == CLS_NOP_SFX);
                default:       ok_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pfx_addr_merge.sv
module pfx_addr_merge #(
    parameter int ADDR_W     = 32,
    parameter int GRAIN_LOG2 = 6,
    parameter int WORD_LOG2  = 2,
    localparam int HI_W      = ADDR_W - GRAIN_LOG2,
    localparam int SAVE_W    = GRAIN_LOG2 - WORD_LOG2
) (
    input  logic [HI_W-1:0]      sfx_hi_i,
    input  logic [SAVE_W-1:0]    saved_i,
    input  logic [WORD_LOG2-1:0] sfx_lo_i,
    output logic [ADDR_W-1:0]    addr_o
);
    always_comb begin
        addr_o = {sfx_hi_i, saved_i, sfx_lo_i};
    end
endmodule

// File: rtl/pfx_fuse_dec.sv
module pfx_fuse_dec
    import pfx_fuse_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int GRAIN_LOG2 = 6,
    parameter int WORD_LOG2  = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 flush_i,
    input  logic                 out_stall_i,
    input  logic                 in_valid_i,
    input  logic [WORD_W-1:0]    in_word_i,
    input  logic [ADDR_W-1:0]    in_addr_i,
    input  logic [CLS_W-1:0]     in_class_i,
    output logic                 out_valid_o,
    output logic [CLS_W-1:0]     out_class_o,
    output logic                 out_fused_o,
    output logic                 out_pfx_ok_o,
    output logic [WORD_W-1:0]    out_prefix_o,
    output logic [WORD_W-1:0]    out_suffix_o,
    output logic [ADDR_W-1:0]    out_addr_o
);
    localparam int SAVE_W = GRAIN_LOG2 - WORD_LOG2;

    typedef struct packed {
        logic               held;
        logic [WORD_W-1:0]  pfx_word;
        logic [SAVE_W-1:0]  pfx_abits;
        logic               o_valid;
        logic [CLS_W-1:0]   o_class;
        logic               o_fused;
        logic               o_ok;
        logic [WORD_W-1:0]  o_prefix;
        logic [WORD_W-1:0]  o_suffix;
        logic [ADDR_W-1:0]  o_addr;
    } state_t;

    state_t st_d, st_q;

    logic              go;
    logic              as_pfx, as_sfx, as_plain;
    logic              pair_ok;
    logic [ADDR_W-1:0] merged_addr;

    assign go = !out_stall_i && !flush_i;

    pfx_word_sort u_sort (
        .vld_i      (in_valid_i),
        .go_i       (go),
        .held_i     (st_q.held),
        .opc_i      (in_word_i[WORD_W-1:OPC_LO]),
        .as_pfx_o   (as_pfx),
        .as_sfx_o   (as_sfx),
        .as_plain_o (as_plain)
    );

    pfx_legal_chk u_legal (
        .hdr_i (st_q.pfx_word[HDR_HI:HDR_LO]),
        .cls_i (in_class_i),
        .ok_o  (pair_ok)
    );

    pfx_addr_merge #(
        .ADDR_W     (ADDR_W),
        .GRAIN_LOG2 (GRAIN_LOG2),
        .WORD_LOG2  (WORD_LOG2)
    ) u_addr (
        .sfx_hi_i (in_addr_i[ADDR_W-1:GRAIN_LOG2]),
        .saved_i  (st_q.pfx_abits),
        .sfx_lo_i (in_addr_i[WORD_LOG2-1:0]),
        .addr_o   (merged_addr)
    );

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.held    = 1'b0;
            st_d.o_valid = 1'b0;
        end else if (!out_stall_i) begin
            st_d.o_valid = 1'b0;
            if (as_pfx) begin
                st_d.held      = 1'b1;
                st_d.pfx_word  = in_word_i;
                st_d.pfx_abits = in_addr_i[GRAIN_LOG2-1:WORD_LOG2];
            end else if (as_sfx) begin
                st_d.held     = 1'b0;
                st_d.o_valid  = 1'b1;
                st_d.o_class  = cls_prefixed(in_class_i);
                st_d.o_fused  = 1'b1;
                st_d.o_ok     = pair_ok;
                st_d.o_prefix = st_q.pfx_word;
                st_d.o_suffix = in_word_i;
                st_d.o_addr   = merged_addr;
            end else if (as_plain) begin
                st_d.o_valid  = 1'b1;
                st_d.o_class  = cls_is_dummy(in_class_i) ? CLS_ILLEGAL : in_class_i;
                st_d.o_fused  = 1'b0;
                st_d.o_ok     = 1'b1;
                st_d.o_prefix = '0;
                st_d.o_suffix = in_word_i;
                st_d.o_addr   = in_addr_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign out_valid_o  = st_q.o_valid;
    assign out_class_o  = st_q.o_class;
    assign out_fused_o  = st_q.o_fused;
    assign out_pfx_ok_o = st_q.o_ok;
    assign out_prefix_o = st_q.o_prefix;
    assign out_suffix_o = st_q.o_suffix;
    assign out_addr_o   = st_q.o_addr;

    AST_PFX_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (in_valid_i && go && !st_q.held && in_word_i[WORD_W-1:OPC_LO] == OPC_PREFIX)
        |=> !out_valid_o); // R2

    AST_FUSED_ODD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_fused_o)
        |-> (out_class_o[0] && out_prefix_o[WORD_W-1:OPC_LO] == OPC_PREFIX)); // R3

    AST_PLAIN_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_fused_o)
        |-> (out_pfx_ok_o && out_prefix_o == '0)); // R4

    AST_NO_LONE_DUMMY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && !out_fused_o)
        |-> (out_class_o != CLS_LD_DW_SFX && out_class_o != CLS_ST_DW_SFX)); // R5

    AST_RSVD_FORM_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_valid_o && out_fused_o && out_prefix_o[HDR_HI:HDR_HI-1] == FORM_RSVD)
        |-> !out_pfx_ok_o); // R6

    AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> (!out_valid_o && !st_q.held)); // R9

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (out_stall_i && !flush_i)
        |=> ($stable(out_valid_o) && $stable(out_class_o) && $stable(out_suffix_o)
             && $stable(out_addr_o) && $stable(st_q.held))); // R10

    AST_IDLE_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!in_valid_i && !out_stall_i) |=> !out_valid_o); // R12

endmodule

// File: tb/pfx_fuse_dec_tb_top.sv
module pfx_fuse_dec_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        stall = 1'b0;
    logic        in_v = 1'b0;
    logic [31:0] in_w = '0;
    logic [31:0] in_a = '0;
    logic [5:0]  in_c = '0;
    logic        o_v, o_fu, o_ok;
    logic [5:0]  o_c;
    logic [31:0] o_pw, o_sw, o_a;

    always #2.5 clk = ~clk;

    pfx_fuse_dec dut_i (
        .clk_i (clk), .rst_ni (rst_n), .flush_i (flush), .out_stall_i (stall),
        .in_valid_i (in_v), .in_word_i (in_w), .in_addr_i (in_a), .in_class_i (in_c),
        .out_valid_o (o_v), .out_class_o (o_c), .out_fused_o (o_fu),
        .out_pfx_ok_o (o_ok), .out_prefix_o (o_pw), .out_suffix_o (o_sw),
        .out_addr_o (o_a)
    );

    typedef struct {
        logic        v;
        logic [5:0]  cls;
        logic        fu;
        logic        ok;
        logic [31:0] pw;
        logic [31:0] sw;
        logic [31:0] ad;
        string       tag;
    } exp_t;

    exp_t q[$];
    exp_t last_e;
    exp_t mon_e;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   done = 1'b0;

    logic        m_held = 1'b0;
    logic [31:0] m_pw = '0;
    logic [31:0] m_pa = '0;

    function automatic logic legal(input logic [31:0] p, input logic [5:0] c);
        if (p[23]) return 1'b0;
        case (p[25:24])
            2'd0:    return (c == 6'd26) || (c == 6'd28) || (c == 6'd30);
            2'd2:    return !c[0] && c >= 6'd2 && c <= 6'd24;
            2'd3:    return c == 6'd32;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] mkpfx(input logic [1:0] form, input logic sub,
                                          input logic [22:0] rest);
        return {6'd1, form, sub, rest};
    endfunction

    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] a,
                        input logic [5:0] c, input logic st, input logic fl,
                        input string tag);
        exp_t e;
        in_v = v; in_w = w; in_a = a; in_c = c; stall = st; flush = fl;
        @(posedge clk);
        e = last_e;
        e.tag = tag;
        if (fl) begin
            m_held = 1'b0;
            e.v = 1'b0;
        end else if (!st) begin
            e.v = 1'b0;
            if (v && m_held) begin
                e = '{1'b1, c | 6'd1, 1'b1, legal(m_pw, c), m_pw, w,
                      {a[31:6], m_pa[5:2], a[1:0]}, tag};
                m_held = 1'b0;
            end else if (v && w[31:26] == 6'd1) begin
                m_held = 1'b1; m_pw = w; m_pa = a;
            end else if (v) begin
                e = '{1'b1, (c == 6'd28 || c == 6'd30) ? 6'd0 : c, 1'b0, 1'b1,
                      32'd0, w, a, tag};
            end
        end
        last_e = e;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 32'd0, 32'd0, 6'd0, 1'b0, 1'b0, tag);
    endtask

    always @(negedge clk) begin
        if (q.size() != 0) begin
            mon_e = q.pop_front();
            n_checks++;
            if (o_v !== mon_e.v) begin
                n_fails++;
                $display("FAIL %s valid actual=%b expected=%b", mon_e.tag, o_v, mon_e.v);
            end else if (mon_e.v && {o_c, o_fu, o_ok, o_pw, o_sw, o_a} !==
                         {mon_e.cls, mon_e.fu, mon_e.ok, mon_e.pw, mon_e.sw, mon_e.ad}) begin
                n_fails++;
                $display("FAIL %s actual cls=%0d fu=%b ok=%b pw=%h sw=%h a=%h expected cls=%0d fu=%b ok=%b pw=%h sw=%h a=%h",
                         mon_e.tag, o_c, o_fu, o_ok, o_pw, o_sw, o_a, mon_e.cls,
                         mon_e.fu, mon_e.ok, mon_e.pw, mon_e.sw, mon_e.ad);
            end
        end
    end

    initial begin
        last_e = '{1'b0, 6'd0, 1'b0, 1'b0, 32'd0, 32'd0, 32'd0, "init"};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (o_v !== 1'b0) begin
            n_fails++;
            $display("FAIL R1 reset valid actual=%b expected=0", o_v);
        end
        // R1 / R4: first plain word after reset is unfused
        step(1'b1, 32'h3800_0010, 32'h0000_1000, 6'd8, 1'b0, 1'b0, "R1");
        step(1'b1, 32'h3800_0020, 32'h0000_1004, 6'd12, 1'b0, 1'b0, "R4");
        // R5: lone doubleword suffix classes decode as illegal
        step(1'b1, 32'hE800_0000, 32'h0000_1008, 6'd28, 1'b0, 1'b0, "R5");
        step(1'b1, 32'hF800_0000, 32'h0000_100C, 6'd30, 1'b0, 1'b0, "R5");
        // R2 / R3 / R6 / R8: modified form + byte load
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h12345), 32'h1000_0038, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8860_0004, 32'h1000_003C, 6'd2, 1'b0, 1'b0, "R8");
        // R3: idle cycles do not consume the held prefix
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h00007), 32'h2000_0014, 6'd1, 1'b0, 1'b0, "R2");
        idle("R3");
        idle("R3");
        step(1'b1, 32'h3860_0001, 32'h2000_0018, 6'd24, 1'b0, 1'b0, "R3");
        // R5 / R6: eight-byte form + doubleword load suffix
        step(1'b1, mkpfx(2'd0, 1'b0, 23'h00001), 32'h3000_0000, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'hE400_0000, 32'h3000_0004, 6'd28, 1'b0, 1'b0, "R5");
        // R7: eight-byte form with byte load is illegal, class still prefixed
        step(1'b1, mkpfx(2'd0, 1'b0, 23'h0), 32'h3000_0020, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8800_0000, 32'h3000_0024, 6'd2, 1'b0, 1'b0, "R7");
        // R6: reserved form
        step(1'b1, mkpfx(2'd1, 1'b0, 23'h0), 32'h3000_0030, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8800_0000, 32'h3000_0034, 6'd2, 1'b0, 1'b0, "R6");
        // R6: subtype bit set
        step(1'b1, mkpfx(2'd2, 1'b1, 23'h0), 32'h3000_0040, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8000_0000, 32'h3000_0044, 6'd8, 1'b0, 1'b0, "R6");
        // R6: prefixed no-op legal, and no-op form with other suffix illegal
        step(1'b1, mkpfx(2'd3, 1'b0, 23'h0), 32'h3000_0058, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h6000_0000, 32'h3000_005C, 6'd32, 1'b0, 1'b0, "R6");
        step(1'b1, mkpfx(2'd3, 1'b0, 23'h0), 32'h3000_0060, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8000_0000, 32'h3000_0064, 6'd8, 1'b0, 1'b0, "R6");
        // R11: prefix followed by prefix -> second is suffix
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h1), 32'h4000_0008, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h2), 32'h4000_000C, 6'd1, 1'b0, 1'b0, "R11");
        step(1'b1, 32'h3800_0030, 32'h4000_0010, 6'd8, 1'b0, 1'b0, "R11");
        // R9: flush drops held prefix; word during flush is discarded
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h3), 32'h5000_0000, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h3800_0040, 32'h5000_0004, 6'd8, 1'b0, 1'b1, "R9");
        step(1'b1, 32'h3800_0040, 32'h5000_0004, 6'd8, 1'b0, 1'b0, "R9");
        step(1'b1, 32'h3800_0050, 32'h5000_0008, 6'd8, 1'b0, 1'b1, "R9");
        idle("R9");
        // R10: stall freezes output and ignores input
        step(1'b1, 32'h3800_0060, 32'h6000_0000, 6'd10, 1'b0, 1'b0, "R10");
        step(1'b1, 32'h3800_0070, 32'h6000_0004, 6'd14, 1'b1, 1'b0, "R10");
        step(1'b1, 32'h3800_0070, 32'h6000_0004, 6'd14, 1'b1, 1'b0, "R10");
        step(1'b1, 32'h3800_0070, 32'h6000_0004, 6'd14, 1'b0, 1'b0, "R10");
        // R10: stall while prefix held keeps it
        step(1'b1, mkpfx(2'd2, 1'b0, 23'h4), 32'h6000_0010, 6'd1, 1'b0, 1'b0, "R2");
        step(1'b1, 32'h8000_0000, 32'h6000_0014, 6'd8, 1'b1, 1'b0, "R10");
        step(1'b1, 32'h8000_0000, 32'h6000_0014, 6'd8, 1'b0, 1'b0, "R10");
        // R12: idle empties the output
        idle("R12");
        idle("R12");
        @(negedge clk);
        n_checks++;
        if (q.size() != 0) begin
            n_fails++;
            $display("FAIL R3 pending items actual=%0d expected=0", q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule